// File: doc/BRIEF.md
# SD Card Identification and Setup Sequencer

This block takes an SD card from power-up to a selected card on a four-bit bus. On a start pulse it sends a fixed series of commands to a command-line engine: reset to idle, the interface-condition probe, the operating-condition loop, CID and address assignment, the CSD and CID reads, card select, and the bus-width switch. At each step it checks the engine's reply. It keeps the OCR word and the relative card address, and works out whether the card is version 1, standard version 2 or high capacity.

On the command side the block is a valid/ready producer. `cmd_valid` rises with the index, argument and response type. All four stay unchanged until a cycle where `cmd_ready` is high. That cycle is the transfer, so the engine applies back-pressure simply by holding `cmd_ready` low. Only one command is in flight at a time. After the transfer the block waits for a single-cycle `rsp_valid` carrying `rsp_err` and `rsp_word`. The block is always ready for that reply, so the response side has no back-pressure.

A free-running one-microsecond `us_tick` times the operating-condition loop. The result pins stay in place until the next start.

Top module: `sdinit_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `cmd_valid` and `ctrl_rst` are low, `err_code` is 0 and `card_kind` is 0.
- R2: The first command is index 0 with argument 0 and response type 0 (none). If it fails, the run ends with `fail` high and `err_code` 1.
- R3: The second command is index 8 with argument 0x1AA and response type 6 (R7). A successful reply whose word is not exactly 0x1AA ends the run with `err_code` 2. A matching reply marks the card as version 2.
- R4: Index 8 is tried at most PROBE_TRIES times (default 3). Between two attempts, after a failure, `ctrl_rst` pulses high for one cycle. If every attempt fails, the card counts as version 1 and the flow goes on.
- R5: Each operating-condition request is index 55 with argument 0, then index 41 with response type 4 (R3). The index-41 argument is 0x40300000 for a version-2 card and 0x00300000 for a version-1 card.
- R6: The index-55/41 pair repeats while reply bit 31 is 0. A failed command in the pair ends the run with `err_code` 3. So does an index-41 reply that arrives after more than BUSY_LIMIT_US ticks since the first index-55 of the loop.
- R7: The final index-41 word is kept on `ocr`. Its bit 30 sets `hcs`. `card_kind` reads 1 for version 1, 2 for standard version 2 and 3 for version 2 with bit 30 set, and it is valid when `done` is high.
- R8: Next come index 2 (type 3, R2) and index 3 (type 5, R6), both with argument 0. `rca` takes bits 31:16 of the index-3 reply.
- R9: Next come indexes 9 and 10 (type R2), then index 7 (type 2, R1b), then index 55, each with argument {rca,16'h0}. Last is index 6 with argument 2. After it succeeds, `done` rises.
- R10: Error codes by failing step: 4 for index 2, 5 for index 3, 6 for index 9, 7 for index 10, 8 for index 7, and 9 for the bus-width pair (index 55 or 6). `err_code` and `fail` hold until the next start, and `err_code` is 0 whenever `done` is high.
- R11: Only one command is outstanding at a time. The request fields hold while `cmd_valid` waits for `cmd_ready`, and no new request appears before the reply arrives.
- R12: `busy` is high from the start pulse until `done` or `fail`. A start pulse while `busy` is high has no effect on the command series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished successfully |
| fail | output | 1 | Run ended with an error |
| err_code | output | 4 | Failing step code, 0 when none |
| card_kind | output | 2 | 0 unknown, 1 v1, 2 v2 standard, 3 v2 high capacity |
| hcs | output | 1 | High-capacity flag |
| ocr | output | 32 | Last operating-condition reply |
| rca | output | 16 | Relative card address |
| ctrl_rst | output | 1 | One-cycle request to reset the command engine |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Engine accepts the request |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rtype | output | 3 | Response type: 0 none, 1 R1, 2 R1b, 3 R2, 4 R3, 5 R6, 6 R7 |
| rsp_valid | input | 1 | Reply present for one cycle |
| rsp_err | input | 1 | Command failed (timeout, CRC or index) |
| rsp_word | input | 32 | Reply word |

## Verification
The assertions assume the engine raises `rsp_valid` only while a request has been taken and its reply is still owed, and only for one cycle. The bench's responder follows this. It answers only after it has taken a request, and it holds `cmd_ready` low for two cycles first, which exercises the hold rule. The microsecond tick is a free-running divide-by-four of the clock. The one-second limit is scaled down through the parameter, so the timeout path is reached within a few tens of loop rounds.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [2:0] {
    RT_NONE = 3'd0, RT_R1 = 3'd1, RT_R1B = 3'd2, RT_R2 = 3'd3,
    RT_R3 = 3'd4, RT_R6 = 3'd5, RT_R7 = 3'd6
  } rtype_e;

  typedef enum logic [3:0] {
    ERR_NONE = 4'd0, ERR_GOIDLE = 4'd1, ERR_PROBE = 4'd2, ERR_OPCOND = 4'd3,
    ERR_ALLCID = 4'd4, ERR_ADDR = 4'd5, ERR_CSD = 4'd6, ERR_CID = 4'd7,
    ERR_SELECT = 4'd8, ERR_WIDTH = 4'd9
  } err_e;

  typedef enum logic [3:0] {
    ST_GOIDLE, ST_PROBE, ST_OC_APP, ST_OC, ST_ALLCID, ST_ADDR,
    ST_CSD, ST_CID, ST_SELECT, ST_BW_APP, ST_BW
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_REQ, PH_WAIT, PH_RST, PH_DONE, PH_FAIL
  } phase_e;

  typedef struct packed {
    logic [5:0] idx;
    rtype_e     rt;
    err_e       err;
  } stepinfo_t;

  localparam logic [31:0] PROBE_PATTERN = 32'h0000_01AA;
  localparam logic [31:0] OC_ARG_V2     = 32'h4030_0000;
  localparam logic [31:0] OC_ARG_V1     = 32'h0030_0000;
  localparam logic [31:0] BUS4_ARG      = 32'h0000_0002;

  function automatic stepinfo_t step_info(step_e s);
    case (s)
      ST_GOIDLE: return '{6'd0,  RT_NONE, ERR_GOIDLE};
      ST_PROBE:  return '{6'd8,  RT_R7,   ERR_PROBE};
      ST_OC_APP: return '{6'd55, RT_R1,   ERR_OPCOND};
      ST_OC:     return '{6'd41, RT_R3,   ERR_OPCOND};
      ST_ALLCID: return '{6'd2,  RT_R2,   ERR_ALLCID};
      ST_ADDR:   return '{6'd3,  RT_R6,   ERR_ADDR};
      ST_CSD:    return '{6'd9,  RT_R2,   ERR_CSD};
      ST_CID:    return '{6'd10, RT_R2,   ERR_CID};
      ST_SELECT: return '{6'd7,  RT_R1B,  ERR_SELECT};
      ST_BW_APP: return '{6'd55, RT_R1,   ERR_WIDTH};
      default:   return '{6'd6,  RT_R1,   ERR_WIDTH};
    endcase
  endfunction

  function automatic step_e next_step(step_e s);
    case (s)
      ST_GOIDLE: return ST_PROBE;
      ST_PROBE:  return ST_OC_APP;
      ST_OC_APP: return ST_OC;
      ST_OC:     return ST_ALLCID;
      ST_ALLCID: return ST_ADDR;
      ST_ADDR:   return ST_CSD;
      ST_CSD:    return ST_CID;
      ST_CID:    return ST_SELECT;
      ST_SELECT: return ST_BW_APP;
      default:   return ST_BW;
    endcase
  endfunction

endpackage

// File: rtl/sdinit_retry_ctr.sv
module sdinit_retry_ctr #(
  parameter int TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(TRIES + 1);
  localparam logic [CW-1:0] LAST_V = CW'(TRIES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);

  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(TRIES)); // R4

endmodule

// File: rtl/sdinit_busy_timer.sv
module sdinit_busy_timer #(
  parameter int LIMIT_US = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT_US + 2);
  localparam logic [CW-1:0] LIM = CW'(LIMIT_US);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (arm) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run && tick && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt > LIM);

  AST_TMR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !arm |=> expired); // R6

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
  import sdinit_pkg::*;
#(
  parameter int PROBE_TRIES   = 3,
  parameter int BUSY_LIMIT_US = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        us_tick,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic [3:0]  err_code,
  output logic [1:0]  card_kind,
  output logic        hcs,
  output logic [31:0] ocr,
  output logic [15:0] rca,
  output logic        ctrl_rst,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [5:0]  cmd_idx,
  output logic [31:0] cmd_arg,
  output logic [2:0]  cmd_rtype,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [31:0] rsp_word
);

  phase_e    phase;
  step_e     step;
  stepinfo_t info;
  err_e      err_q;
  logic      is_v2;
  logic      probe_last, oc_expired;
  logic      launch, rsp_take, probe_bump, timer_arm;

  assign info      = step_info(step);
  assign busy      = (phase == PH_REQ) || (phase == PH_WAIT) || (phase == PH_RST);
  assign done      = (phase == PH_DONE);
  assign fail      = (phase == PH_FAIL);
  assign ctrl_rst  = (phase == PH_RST);
  assign cmd_valid = (phase == PH_REQ);
  assign cmd_idx   = info.idx;
  assign cmd_rtype = info.rt;
  assign err_code  = err_q;

  always_comb begin
    case (step)
      ST_PROBE:  cmd_arg = PROBE_PATTERN;
      ST_OC:     cmd_arg = is_v2 ? OC_ARG_V2 : OC_ARG_V1;
      ST_CSD, ST_CID, ST_SELECT, ST_BW_APP: cmd_arg = {rca, 16'h0000};
      ST_BW:     cmd_arg = BUS4_ARG;
      default:   cmd_arg = 32'h0;
    endcase
  end

  assign launch     = start && !busy;
  assign rsp_take   = (phase == PH_WAIT) && rsp_valid;
  assign probe_bump = rsp_take && (step == ST_PROBE) && rsp_err && !probe_last;
  assign timer_arm  = rsp_take && (step == ST_PROBE);

  sdinit_retry_ctr #(.TRIES(PROBE_TRIES)) retry_i (
    .clk(clk), .rst_n(rst_n), .clr(launch), .bump(probe_bump), .last(probe_last)
  );

  sdinit_busy_timer #(.LIMIT_US(BUSY_LIMIT_US)) timer_i (
    .clk(clk), .rst_n(rst_n), .arm(timer_arm), .tick(us_tick), .expired(oc_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      step      <= ST_GOIDLE;
      err_q     <= ERR_NONE;
      is_v2     <= 1'b0;
      hcs       <= 1'b0;
      ocr       <= '0;
      rca       <= '0;
      card_kind <= '0;
    end else begin
      case (phase)
        PH_REQ:  if (cmd_ready) phase <= PH_WAIT;
        PH_RST:  phase <= PH_REQ;
        PH_WAIT: if (rsp_valid) begin
          case (step)
            ST_PROBE: begin
              if (!rsp_err) begin
                if (rsp_word == PROBE_PATTERN) begin
                  is_v2 <= 1'b1;
                  step  <= ST_OC_APP;
                  phase <= PH_REQ;
                end else begin
                  err_q <= info.err;
                  phase <= PH_FAIL;
                end
              end else if (probe_last) begin
                step  <= ST_OC_APP;
                phase <= PH_REQ;
              end else begin
                phase <= PH_RST;
              end
            end
            ST_OC: begin
              if (rsp_err || oc_expired) begin
                err_q <= info.err;
                phase <= PH_FAIL;
              end else if (rsp_word[31]) begin
                ocr   <= rsp_word;
                hcs   <= rsp_word[30];
                step  <= ST_ALLCID;
                phase <= PH_REQ;
              end else begin
                step  <= ST_OC_APP;
                phase <= PH_REQ;
              end
            end
            default: begin
              if (rsp_err) begin
                err_q <= info.err;
                phase <= PH_FAIL;
              end else if (step == ST_BW) begin
                card_kind <= !is_v2 ? 2'd1 : (hcs ? 2'd3 : 2'd2);
                phase     <= PH_DONE;
              end else begin
                if (step == ST_ADDR) rca <= rsp_word[31:16];
                step  <= next_step(step);
                phase <= PH_REQ;
              end
            end
          endcase
        end
        default: if (start) begin
          phase     <= PH_REQ;
          step      <= ST_GOIDLE;
          err_q     <= ERR_NONE;
          is_v2     <= 1'b0;
          hcs       <= 1'b0;
          ocr       <= '0;
          rca       <= '0;
          card_kind <= '0;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_idx) && $stable(cmd_arg)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid); // R11
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> phase == PH_WAIT); // R11
  AST_RST_THEN_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> cmd_valid && cmd_idx == 6'd8); // R4
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail && $stable(err_code)); // R10
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_code == 4'd0 && card_kind != 2'd0); // R10
  AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done || fail); // R12
  AST_SELECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_idx == 6'd7 |-> cmd_arg == {rca, 16'h0000}); // R9

endmodule

// File: tb/sdinit_seq_tb_top.sv
module sdinit_seq_tb_top;

  localparam int TRIES = 3;
  localparam int LIMIT = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0;
  logic busy, done, fail, hcs, ctrl_rst, cmd_valid;
  logic cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [31:0] rsp_word = '0;
  logic [3:0] err_code;
  logic [1:0] card_kind;
  logic [31:0] ocr, cmd_arg;
  logic [15:0] rca;
  logic [5:0] cmd_idx;
  logic [2:0] cmd_rtype;

  always #2 clk = ~clk;

  sdinit_seq #(.PROBE_TRIES(TRIES), .BUSY_LIMIT_US(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .busy(busy), .done(done), .fail(fail), .err_code(err_code),
    .card_kind(card_kind), .hcs(hcs), .ocr(ocr), .rca(rca),
    .ctrl_rst(ctrl_rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_rtype(cmd_rtype),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_word(rsp_word)
  );

  int errors = 0, checks = 0;

  int          fail_idx = -1;
  int          cmd8_fails = 0;
  logic [31:0] cmd8_echo = 32'h1AA;
  int          a41_busy = 0;
  bit          a41_hc = 1'b0;
  bit          a41_never = 1'b0;
  logic [15:0] card_rca = 16'hABCD;

  int          n_log = 0, n_rst = 0, hs_viol = 0;
  logic [5:0]  log_idx [64];
  logic [31:0] log_arg [64];
  logic [2:0]  log_rt  [64];

  int tick_div = 0;
  always @(posedge clk) begin
    tick_div <= (tick_div + 1) % 4;
    us_tick  <= (tick_div == 3);
    if (ctrl_rst) n_rst <= n_rst + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // command-line engine model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [5:0]  i0;
        logic [31:0] a0;
        logic        e;
        logic [31:0] w;
        i0 = cmd_idx;
        a0 = cmd_arg;
        repeat (2) @(negedge clk);
        if (!cmd_valid || cmd_idx != i0 || cmd_arg != a0) hs_viol++;
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (n_log < 64) begin
          log_idx[n_log] = i0;
          log_arg[n_log] = a0;
          log_rt[n_log]  = cmd_rtype;
        end
        n_log++;
        repeat (3) begin
          if (cmd_valid) hs_viol++;
          @(negedge clk);
        end
        e = (int'(i0) == fail_idx);
        w = 32'h0;
        case (i0)
          6'd8: begin
            w = cmd8_echo;
            if (cmd8_fails > 0) begin e = 1'b1; cmd8_fails--; end
          end
          6'd41: begin
            if (a41_never) w = 32'h00FF8000;
            else if (a41_busy > 0) begin w = 32'h00FF8000; a41_busy--; end
            else w = {1'b1, a41_hc, 30'h00FF8000};
          end
          6'd3: w = {card_rca, 16'h0500};
          default: w = 32'h0;
        endcase
        rsp_err   = e;
        rsp_word  = w;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
      end
    end
  end

  task automatic configure(input int f_idx, input int c8f, input logic [31:0] echo,
                           input int busy_n, input bit hc, input bit never);
    fail_idx = f_idx; cmd8_fails = c8f; cmd8_echo = echo;
    a41_busy = busy_n; a41_hc = hc; a41_never = never;
  endtask

  task automatic run(input bit poke_start);
    n_log = 0; n_rst = 0; hs_viol = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      if (poke_start && c == 30) start = 1'b1;
      if (poke_start && c == 31) start = 1'b0;
      if (done || fail) break;
      @(negedge clk);
    end
    chk(done || fail, "R12", "run finished", {30'b0, done, fail}, 32'h1);
    chk(hs_viol == 0, "R11", "handshake violations", hs_viol, 0);
    chk(!busy, "R12", "busy low at end", busy, 0);
  endtask

  task automatic exp_cmd(input int p, input logic [5:0] idx, input logic [31:0] arg,
                         input string req);
    chk(p < n_log && log_idx[p] == idx, req, $sformatf("index at %0d", p), log_idx[p], idx);
    chk(p < n_log && log_arg[p] == arg, req, $sformatf("arg at %0d", p), log_arg[p], arg);
  endtask

  task automatic exp_tail(input int p, input logic [31:0] ra);
    exp_cmd(p,   6'd2,  32'h0, "R8");
    exp_cmd(p+1, 6'd3,  32'h0, "R8");
    exp_cmd(p+2, 6'd9,  ra,    "R9");
    exp_cmd(p+3, 6'd10, ra,    "R9");
    exp_cmd(p+4, 6'd7,  ra,    "R9");
    exp_cmd(p+5, 6'd55, ra,    "R9");
    exp_cmd(p+6, 6'd6,  32'h2, "R9");
  endtask

  task automatic t_reset;
    chk(!busy && !done && !fail, "R1", "status idle", {busy, done, fail}, 0);
    chk(err_code == 0 && card_kind == 0, "R1", "codes zero", {err_code, card_kind}, 0);
    chk(!cmd_valid && !ctrl_rst, "R1", "no request", {cmd_valid, ctrl_rst}, 0);
  endtask

  task automatic t_high_capacity(input bit poke);
    configure(-1, 0, 32'h1AA, 2, 1'b1, 1'b0);
    card_rca = 16'hABCD;
    run(poke);
    chk(done && !fail, "R9", "done", done, 1);
    chk(n_log == 15, poke ? "R12" : "R9", "command count", n_log, 15);
    exp_cmd(0, 6'd0, 32'h0, "R2");
    chk(log_rt[0] == 3'd0, "R2", "go-idle type", log_rt[0], 0);
    exp_cmd(1, 6'd8, 32'h1AA, "R3");
    chk(log_rt[1] == 3'd6, "R3", "probe type", log_rt[1], 6);
    for (int k = 0; k < 3; k++) begin
      exp_cmd(2 + 2*k, 6'd55, 32'h0, "R5");
      exp_cmd(3 + 2*k, 6'd41, 32'h40300000, "R6");
    end
    chk(log_rt[3] == 3'd4, "R5", "opcond type", log_rt[3], 4);
    exp_tail(8, 32'hABCD0000);
    chk(log_rt[8] == 3'd3 && log_rt[9] == 3'd5 && log_rt[12] == 3'd2, "R8",
        "R2/R6/R1b types", {log_rt[8], log_rt[9], log_rt[12]}, {3'd3, 3'd5, 3'd2});
    chk(card_kind == 2'd3 && hcs, "R7", "kind high capacity", {card_kind, hcs}, {2'd3, 1'b1});
    chk(ocr == 32'hC0FF8000, "R7", "ocr", ocr, 32'hC0FF8000);
    chk(rca == 16'hABCD, "R8", "rca", rca, 16'hABCD);
    chk(n_rst == 0 && err_code == 0, "R10", "no reset, no error", {n_rst[27:0], err_code}, 0);
  endtask

  task automatic t_version1;
    configure(-1, 3, 32'h1AA, 0, 1'b0, 1'b0);
    card_rca = 16'h1234;
    run(1'b0);
    chk(done, "R4", "v1 done", done, 1);
    chk(n_rst == 2, "R4", "engine reset pulses", n_rst, 2);
    exp_cmd(1, 6'd8, 32'h1AA, "R4");
    exp_cmd(2, 6'd8, 32'h1AA, "R4");
    exp_cmd(3, 6'd8, 32'h1AA, "R4");
    exp_cmd(4, 6'd55, 32'h0, "R5");
    exp_cmd(5, 6'd41, 32'h00300000, "R5");
    exp_tail(6, 32'h12340000);
    chk(card_kind == 2'd1 && !hcs, "R7", "kind v1", {card_kind, hcs}, {2'd1, 1'b0});
  endtask

  task automatic t_probe_retry;
    configure(-1, 1, 32'h1AA, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(done && n_rst == 1, "R4", "one retry", {done, n_rst[30:0]}, {1'b1, 31'd1});
    exp_cmd(3, 6'd55, 32'h0, "R4");
    exp_cmd(4, 6'd41, 32'h40300000, "R5");
    chk(card_kind == 2'd2, "R7", "kind v2 standard", card_kind, 2);
  endtask

  task automatic t_echo_bad;
    configure(-1, 0, 32'h1AB, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(fail && err_code == 4'd2, "R3", "echo mismatch", err_code, 2);
    chk(n_log == 2, "R3", "stopped after probe", n_log, 2);
  endtask

  task automatic t_goidle_fail;
    configure(0, 0, 32'h1AA, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(fail && err_code == 4'd1, "R2", "go-idle error", err_code, 1);
    chk(n_log == 1, "R2", "single command", n_log, 1);
  endtask

  task automatic t_timeout;
    configure(-1, 0, 32'h1AA, 0, 1'b0, 1'b1);
    run(1'b0);
    chk(fail && err_code == 4'd3, "R6", "opcond timeout", err_code, 3);
    chk(n_log > 4 && n_log <= 64 && log_idx[n_log-1] == 6'd41, "R6", "ended on 41",
        log_idx[(n_log > 0 && n_log <= 64) ? n_log-1 : 0], 41);
  endtask

  task automatic t_addr_fail;
    configure(3, 0, 32'h1AA, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(fail && err_code == 4'd5, "R10", "addr error", err_code, 5);
    chk(n_log == 6 && rca == 16'h0, "R10", "stopped at addr", n_log, 6);
    repeat (40) @(negedge clk);
    chk(fail && err_code == 4'd5, "R10", "error held", err_code, 5);
  endtask

  task automatic t_width_fail;
    configure(6, 0, 32'h1AA, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(fail && err_code == 4'd9, "R10", "bus-width error", err_code, 9);
    chk(n_log == 11 && card_kind == 2'd0, "R10", "no kind on fail", {n_log[29:0], card_kind}, {30'd11, 2'd0});
  endtask

  task automatic t_select_fail;
    configure(7, 0, 32'h1AA, 0, 1'b0, 1'b0);
    run(1'b0);
    chk(fail && err_code == 4'd8, "R10", "select error", err_code, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_capacity(1'b0);
    t_version1();
    t_probe_retry();
    t_echo_bad();
    t_goidle_fail();
    t_timeout();
    t_addr_fail();
    t_width_fail();
    t_select_fail();
    t_high_capacity(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule